// File: doc/BRIEF.md
# Dual-Bank ECC-Carrying Tightly Coupled RAM Wrapper

This block sits on the slave side of a processor's tightly coupled memory port. The processor computes its own error-correcting code. It presents a 64-bit data word and an 8-bit check code on every write, and it expects both back on every read. The wrapper does no encoding or decoding. It stores the check bits unchanged and returns them unchanged.

Each 72-bit word is spread over two 36-bit-wide RAM banks that sit outside the block. The bytes are interleaved: even bytes go to one bank and odd bytes go to the other. Each bank also holds one nibble of the check code. Each bank has its own select and write-enable, driven by its own address decoder, and the two decoders are built differently. A disagreement between them raises a flag.

The wrapper also provides the following:
- The request address carries an even-parity bit. An access with bad parity is blocked and flagged.
- Single-bit and multi-bit error events arrive from the processor. Each type latches its address in its own sticky register and raises a level interrupt.
- On command, an initialization sequencer writes a fixed pattern, check bits included, to every location of both banks. Processor requests are stalled while it runs.

Top module: `tcram_wrap`

## Requirements
- R1: A write with good parity to an address below DEPTH drives both banks in the request cycle with select, data write-enable and check write-enable high, and with the same address. Bank 0 data bits [8k+7:8k] hold word byte 2k, and its bits [35:32] hold check bits [3:0]. Bank 1 data bits [8k+7:8k] hold word byte 2k+1, and its bits [35:32] hold check bits [7:4], for k = 0..3.
- R2: A read with good parity to an address below DEPTH raises `cpu_rvalid` exactly one cycle later. In that cycle it returns the merged word and check code that were last written to that address.
- R3: Address parity is even over {`cpu_addr`, `cpu_addr_par`}. A request whose parity is odd selects no bank, produces no `cpu_rvalid`, leaves memory contents unchanged, and raises `addr_par_err` for one cycle in the following cycle.
- R4: Bank 0 controls come from one decoder and bank 1 controls from a second, differently built decoder. In normal operation both banks always see equal select and address, and `dec_err` stays low.
- R5: A single-bit event (`evt_sbe`) when no single-bit error is pending sets `sbe_irq` and latches `evt_addr` into `sbe_addr` on the next cycle. Later events keep the first address while the flag is set.
- R6: Multi-bit events (`evt_mbe`) behave as in R5 using `mbe_irq` and `mbe_addr`, independently of the single-bit path.
- R7: `clr_sbe` / `clr_mbe` clears the matching flag on the next cycle. An event of that type in the same cycle as its clear is captured as a new first address.
- R8: A pulse on `init_start` while idle makes `cpu_ready` low for exactly DEPTH cycles, starting the next cycle. In those cycles both banks are written at addresses 0, 1, … DEPTH-1 in ascending order with INIT_DATA and INIT_ECC, split as in R1.
- R9: `init_done` is low from the first initialization cycle and goes high in the cycle after the last address is written. Requests presented while `cpu_ready` is low produce no `cpu_rvalid`.
- R10: Requests to addresses at or above DEPTH select no bank and produce no `cpu_rvalid`.
- R11: After reset, `cpu_ready` is high, and both interrupts, `init_done`, `addr_par_err`, `dec_err` and both bank selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = full-word write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_addr_par | input | 1 | Even-parity bit over the address |
| cpu_wdata | input | 64 | Write data |
| cpu_wecc | input | 8 | Check code from the processor |
| cpu_ready | output | 1 | Low while initialization is running |
| cpu_rvalid | output | 1 | Read data valid, one cycle after the request |
| cpu_rdata | output | 64 | Read data |
| cpu_recc | output | 8 | Stored check code |
| evt_sbe | input | 1 | Single-bit error event |
| evt_mbe | input | 1 | Multi-bit error event |
| evt_addr | input | ADDR_W | Address of the reported error |
| clr_sbe | input | 1 | Clear the single-bit flag |
| clr_mbe | input | 1 | Clear the multi-bit flag |
| sbe_irq | output | 1 | Single-bit error pending |
| mbe_irq | output | 1 | Multi-bit error pending |
| sbe_addr | output | ADDR_W | First single-bit error address |
| mbe_addr | output | ADDR_W | First multi-bit error address |
| addr_par_err | output | 1 | Address parity error pulse |
| dec_err | output | 1 | Redundant decoder mismatch |
| init_start | input | 1 | Start auto-initialization |
| init_done | output | 1 | Initialization finished |
| b0_cs | output | 1 | Bank 0 select |
| b0_we | output | 1 | Bank 0 data write enable |
| b0_ewe | output | 1 | Bank 0 check-nibble write enable |
| b0_addr | output | ADDR_W | Bank 0 address |
| b0_wdata | output | 36 | Bank 0 write word |
| b0_rdata | input | 36 | Bank 0 read word (registered in the RAM) |
| b1_cs | output | 1 | Bank 1 select |
| b1_we | output | 1 | Bank 1 data write enable |
| b1_ewe | output | 1 | Bank 1 check-nibble write enable |
| b1_addr | output | ADDR_W | Bank 1 address |
| b1_wdata | output | 36 | Bank 1 write word |
| b1_rdata | input | 36 | Bank 1 read word (registered in the RAM) |

## Verification
A wrong lane mapping in the split or merge shows up in the request cycle as a bank word that differs from the byte-by-byte expectation. It also shows up one cycle later as a read that does not match the written word. A sequencer counter that is off by one lengthens or shortens the low time of `cpu_ready`, or sends an address out of order. Either fault shows up within the DEPTH-cycle initialization window. A lost sticky hold or a wrong clear priority changes `sbe_addr`, `mbe_addr` or an interrupt on the cycle after the offending event. A parity fault either writes memory, which a later read exposes, or misplaces the `addr_par_err` pulse on the next cycle.

// File: rtl/tcram_pkg.sv
package tcram_pkg;

    localparam int DATA_W = 64;
    localparam int ECC_W  = 8;
    localparam int BANK_W = 36;
    localparam int LANES  = 4;   // bytes per bank

    typedef enum logic [0:0] {ST_IDLE, ST_INIT} seq_st_e;

    typedef struct packed {
        logic rvalid;
        logic par_err;
        logic dec_err;
    } wrap_st_t;

    // Bank word: odd=0 takes even bytes and ECC[3:0]; odd=1 takes odd bytes and ECC[7:4].
    function automatic logic [BANK_W-1:0] bank_pack(input logic [DATA_W-1:0] d,
                                                    input logic [ECC_W-1:0]  e,
                                                    input logic              odd);
        logic [BANK_W-1:0] w;
        int                base;
        base = odd ? 8 : 0;
        w = '0;
        for (int k = 0; k < LANES; k++) begin
            w[8*k +: 8] = d[16*k + base +: 8];
        end
        w[35:32] = odd ? e[7:4] : e[3:0];
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] bank_merge(input logic [BANK_W-1:0] even_w,
                                                     input logic [BANK_W-1:0] odd_w);
        logic [DATA_W-1:0] d;
        for (int k = 0; k < LANES; k++) begin
            d[16*k     +: 8] = even_w[8*k +: 8];
            d[16*k + 8 +: 8] = odd_w[8*k +: 8];
        end
        return d;
    endfunction

endpackage

// File: rtl/tcram_addr_dec.sv
module tcram_addr_dec #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 12,
    parameter int STYLE  = 0
) (
    input  logic              req_ok,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              cs,
    output logic              ecc_sel
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W:0] TOP   = (ADDR_W+1)'(DEPTH - 1);

    logic in_range;

    generate
        if (STYLE == 0) begin : g_below
            assign in_range = ({1'b0, addr} < LIMIT);
        end else begin : g_not_above
            assign in_range = !({1'b0, addr} > TOP);
        end
    endgenerate

    assign cs      = req_ok && in_range;
    assign ecc_sel = cs && we;
endmodule

// File: rtl/tcram_init_seq.sv
module tcram_init_seq
    import tcram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] cnt;
        logic              done;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_INIT;
                    s_d.cnt  = '0;
                    s_d.done = 1'b0;
                end
            end
            ST_INIT: begin
                if (s_q.cnt == LAST) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st == ST_INIT);
    assign addr = s_q.cnt;
    assign done = s_q.done;
endmodule

// File: rtl/tcram_err_cap.sv
module tcram_err_cap #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              clr,
    output logic              flag,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.flag = 1'b0;
        end
        if (evt && (!c_q.flag || clr)) begin
            c_d.flag = 1'b1;
            c_d.addr = evt_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign flag = c_q.flag;
    assign addr = c_q.addr;
endmodule

// File: rtl/tcram_wrap.sv
module tcram_wrap
    import tcram_pkg::*;
#(
    parameter int                 ADDR_W    = 4,
    parameter int                 DEPTH     = 12,
    parameter logic [DATA_W-1:0]  INIT_DATA = 64'h0,
    parameter logic [ECC_W-1:0]   INIT_ECC  = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_addr_par,
    input  logic [63:0]       cpu_wdata,
    input  logic [7:0]        cpu_wecc,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [63:0]       cpu_rdata,
    output logic [7:0]        cpu_recc,
    input  logic              evt_sbe,
    input  logic              evt_mbe,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              clr_sbe,
    input  logic              clr_mbe,
    output logic              sbe_irq,
    output logic              mbe_irq,
    output logic [ADDR_W-1:0] sbe_addr,
    output logic [ADDR_W-1:0] mbe_addr,
    output logic              addr_par_err,
    output logic              dec_err,
    input  logic              init_start,
    output logic              init_done,
    output logic              b0_cs,
    output logic              b0_we,
    output logic              b0_ewe,
    output logic [ADDR_W-1:0] b0_addr,
    output logic [35:0]       b0_wdata,
    input  logic [35:0]       b0_rdata,
    output logic              b1_cs,
    output logic              b1_we,
    output logic              b1_ewe,
    output logic [ADDR_W-1:0] b1_addr,
    output logic [35:0]       b1_wdata,
    input  logic [35:0]       b1_rdata
);
    localparam int N_BANK = 2;

    logic              init_busy;
    logic [ADDR_W-1:0] init_addr;
    logic              par_ok, accept, req_ok;
    logic [N_BANK-1:0] dec_cs, dec_ecc;
    wrap_st_t          w_q, w_d;

    tcram_init_seq #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (init_start),
        .busy  (init_busy),
        .addr  (init_addr),
        .done  (init_done)
    );

    // one decoder per bank, each built a different way
    generate
        for (genvar b = 0; b < N_BANK; b++) begin : g_dec
            tcram_addr_dec #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .STYLE(b)) u_dec (
                .req_ok  (req_ok),
                .we      (cpu_we),
                .addr    (cpu_addr),
                .cs      (dec_cs[b]),
                .ecc_sel (dec_ecc[b])
            );
        end
    endgenerate

    tcram_err_cap #(.ADDR_W(ADDR_W)) u_sbe (
        .clk (clk), .rst_n (rst_n), .evt (evt_sbe), .evt_addr (evt_addr),
        .clr (clr_sbe), .flag (sbe_irq), .addr (sbe_addr)
    );

    tcram_err_cap #(.ADDR_W(ADDR_W)) u_mbe (
        .clk (clk), .rst_n (rst_n), .evt (evt_mbe), .evt_addr (evt_addr),
        .clr (clr_mbe), .flag (mbe_irq), .addr (mbe_addr)
    );

    always_comb begin
        par_ok    = ~^{cpu_addr, cpu_addr_par};
        cpu_ready = !init_busy;
        accept    = cpu_req && cpu_ready;
        req_ok    = accept && par_ok;

        if (init_busy) begin
            b0_cs    = 1'b1;
            b0_we    = 1'b1;
            b0_ewe   = 1'b1;
            b0_addr  = init_addr;
            b0_wdata = bank_pack(INIT_DATA, INIT_ECC, 1'b0);
            b1_cs    = 1'b1;
            b1_we    = 1'b1;
            b1_ewe   = 1'b1;
            b1_addr  = init_addr;
            b1_wdata = bank_pack(INIT_DATA, INIT_ECC, 1'b1);
        end else begin
            b0_cs    = dec_cs[0];
            b0_we    = dec_cs[0] && cpu_we;
            b0_ewe   = dec_ecc[0];
            b0_addr  = cpu_addr;
            b0_wdata = bank_pack(cpu_wdata, cpu_wecc, 1'b0);
            b1_cs    = dec_cs[1];
            b1_we    = dec_cs[1] && cpu_we;
            b1_ewe   = dec_ecc[1];
            b1_addr  = cpu_addr;
            b1_wdata = bank_pack(cpu_wdata, cpu_wecc, 1'b1);
        end

        w_d.rvalid  = dec_cs[0] && dec_cs[1] && !cpu_we;
        w_d.par_err = accept && !par_ok;
        w_d.dec_err = (dec_cs[0] != dec_cs[1]) || (dec_ecc[0] != dec_ecc[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign cpu_rvalid   = w_q.rvalid;
    assign cpu_rdata    = w_q.rvalid ? bank_merge(b0_rdata, b1_rdata) : '0;
    assign cpu_recc     = w_q.rvalid ? {b1_rdata[35:32], b0_rdata[35:32]} : '0;
    assign addr_par_err = w_q.par_err;
    assign dec_err      = w_q.dec_err;
endmodule

// File: rtl/tcram_wrap_chk.sv
module tcram_wrap_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_addr_par,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              addr_par_err,
    input logic              dec_err,
    input logic              evt_sbe,
    input logic              evt_mbe,
    input logic              clr_sbe,
    input logic              clr_mbe,
    input logic              sbe_irq,
    input logic              mbe_irq,
    input logic [ADDR_W-1:0] sbe_addr,
    input logic [ADDR_W-1:0] mbe_addr,
    input logic              b0_cs,
    input logic              b0_we,
    input logic              b0_ewe,
    input logic [ADDR_W-1:0] b0_addr,
    input logic              b1_cs,
    input logic [ADDR_W-1:0] b1_addr
);
    AST_PAR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && ^{cpu_addr, cpu_addr_par}) |-> (!b0_cs && !b1_cs)); // R3

    AST_PAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && ^{cpu_addr, cpu_addr_par}) |=> (addr_par_err && !cpu_rvalid)); // R3

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && b0_cs && !b0_we) |=> cpu_rvalid); // R2

    AST_BANK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (b0_cs == b1_cs) && (!b0_cs || (b0_addr == b1_addr))); // R4

    AST_NO_DEC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_err); // R4

    AST_INIT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (b0_cs && b0_we && b0_ewe)); // R8

    AST_STALL_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ready && cpu_req) |=> !cpu_rvalid); // R9

    AST_SBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_irq && !clr_sbe) |=> (sbe_irq && $stable(sbe_addr))); // R5

    AST_MBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_irq && !clr_mbe) |=> (mbe_irq && $stable(mbe_addr))); // R6

    AST_SBE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sbe && !evt_sbe) |=> !sbe_irq); // R7

    AST_MBE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mbe && !evt_mbe) |=> !mbe_irq); // R7
endmodule

bind tcram_wrap tcram_wrap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_addr_par (cpu_addr_par),
    .cpu_ready    (cpu_ready),
    .cpu_rvalid   (cpu_rvalid),
    .addr_par_err (addr_par_err),
    .dec_err      (dec_err),
    .evt_sbe      (evt_sbe),
    .evt_mbe      (evt_mbe),
    .clr_sbe      (clr_sbe),
    .clr_mbe      (clr_mbe),
    .sbe_irq      (sbe_irq),
    .mbe_irq      (mbe_irq),
    .sbe_addr     (sbe_addr),
    .mbe_addr     (mbe_addr),
    .b0_cs        (b0_cs),
    .b0_we        (b0_we),
    .b0_ewe       (b0_ewe),
    .b0_addr      (b0_addr),
    .b1_cs        (b1_cs),
    .b1_addr      (b1_addr)
);

// File: tb/sim_tcram_wrap.sv
module sim_tcram_wrap;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 4;
    localparam int          DEPTH      = 12;
    localparam logic [63:0] IDATA      = 64'h0;
    localparam logic [7:0]  IECC       = 8'h0C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_addr_par = 1'b0;
    logic [AW-1:0] cpu_addr = '0, evt_addr = '0;
    logic [63:0] cpu_wdata = '0;
    logic [7:0]  cpu_wecc = '0;
    logic cpu_ready, cpu_rvalid;
    logic [63:0] cpu_rdata;
    logic [7:0]  cpu_recc;
    logic evt_sbe = 1'b0, evt_mbe = 1'b0, clr_sbe = 1'b0, clr_mbe = 1'b0;
    logic sbe_irq, mbe_irq, addr_par_err, dec_err, init_done;
    logic init_start = 1'b0;
    logic [AW-1:0] sbe_addr, mbe_addr, b0_addr, b1_addr;
    logic b0_cs, b0_we, b0_ewe, b1_cs, b1_we, b1_ewe;
    logic [35:0] b0_wdata, b1_wdata;
    logic [35:0] b0_rdata = '0, b1_rdata = '0;

    logic [35:0] m0 [DEPTH];
    logic [35:0] m1 [DEPTH];

    int n_vec = 0;
    int n_bad = 0;
    logic dec_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcram_wrap #(.ADDR_W(AW), .DEPTH(DEPTH), .INIT_DATA(IDATA), .INIT_ECC(IECC)) u0 (
        .clk (clk), .rst_n (rst_n),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
        .cpu_addr_par (cpu_addr_par), .cpu_wdata (cpu_wdata), .cpu_wecc (cpu_wecc),
        .cpu_ready (cpu_ready), .cpu_rvalid (cpu_rvalid), .cpu_rdata (cpu_rdata),
        .cpu_recc (cpu_recc), .evt_sbe (evt_sbe), .evt_mbe (evt_mbe),
        .evt_addr (evt_addr), .clr_sbe (clr_sbe), .clr_mbe (clr_mbe),
        .sbe_irq (sbe_irq), .mbe_irq (mbe_irq), .sbe_addr (sbe_addr),
        .mbe_addr (mbe_addr), .addr_par_err (addr_par_err), .dec_err (dec_err),
        .init_start (init_start), .init_done (init_done),
        .b0_cs (b0_cs), .b0_we (b0_we), .b0_ewe (b0_ewe), .b0_addr (b0_addr),
        .b0_wdata (b0_wdata), .b0_rdata (b0_rdata),
        .b1_cs (b1_cs), .b1_we (b1_we), .b1_ewe (b1_ewe), .b1_addr (b1_addr),
        .b1_wdata (b1_wdata), .b1_rdata (b1_rdata)
    );

    // behavioural banks, registered read
    always @(posedge clk) begin
        if (b0_cs && int'(b0_addr) < DEPTH) begin
            if (b0_we)  m0[b0_addr][31:0]  <= b0_wdata[31:0];
            if (b0_ewe) m0[b0_addr][35:32] <= b0_wdata[35:32];
            if (!b0_we) b0_rdata <= m0[b0_addr];
        end
        if (b1_cs && int'(b1_addr) < DEPTH) begin
            if (b1_we)  m1[b1_addr][31:0]  <= b1_wdata[31:0];
            if (b1_ewe) m1[b1_addr][35:32] <= b1_wdata[35:32];
            if (!b1_we) b1_rdata <= m1[b1_addr];
        end
    end

    always @(negedge clk) if (rst_n && dec_err) dec_seen = 1'b1;

    function automatic logic [35:0] exp_bank(input logic [63:0] d, input logic [7:0] e, input int odd);
        logic [35:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = d[(2*k + odd)*8 +: 8];
        r[35:32] = (odd == 1) ? e[7:4] : e[3:0];
        return r;
    endfunction

    function automatic logic [63:0] pat_d(input int a);
        logic [3:0] v;
        v = 4'(a);
        return 64'h0123_4567_89AB_CDEF ^ {16{v}};
    endfunction

    function automatic logic [7:0] pat_e(input int a);
        logic [3:0] v;
        v = 4'(a);
        return {v, ~v};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic do_write(input int a, input logic [63:0] d, input logic [7:0] e, input logic flip);
        logic [AW-1:0] av;
        logic sel_exp;
        av = AW'(a);
        sel_exp = !flip && (a < DEPTH);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = av;
        cpu_addr_par = (^av) ^ flip; cpu_wdata = d; cpu_wecc = e;
        #1;
        // R1 / R3 / R10: bank controls in the request cycle
        chk(b0_cs == sel_exp && b1_cs == sel_exp, "R1 bank select", {b0_cs, b1_cs}, {sel_exp, sel_exp});
        if (sel_exp) begin
            chk(b0_we && b0_ewe && b1_we && b1_ewe, "R1 write enables",
                {b0_we, b0_ewe, b1_we, b1_ewe}, 4'hF);
            chk(b0_addr == av && b1_addr == av, "R1 bank address", {b0_addr, b1_addr}, {av, av});
            chk(b0_wdata == exp_bank(d, e, 0), "R1 even bank word", b0_wdata, exp_bank(d, e, 0));
            chk(b1_wdata == exp_bank(d, e, 1), "R1 odd bank word", b1_wdata, exp_bank(d, e, 1));
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(addr_par_err == flip, "R3 parity flag", addr_par_err, flip);
    endtask

    task automatic do_read(input int a, input logic flip, input logic vld_exp,
                           input logic [63:0] d, input logic [7:0] e);
        logic [AW-1:0] av;
        av = AW'(a);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = av; cpu_addr_par = (^av) ^ flip;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_rvalid == vld_exp, "R2 rvalid", cpu_rvalid, vld_exp);
        if (vld_exp) begin
            chk(cpu_rdata == d, "R2 read data", cpu_rdata, d);
            chk(cpu_recc == e, "R2 read ecc", cpu_recc, e);
        end
    endtask

    task automatic run_init;
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_addr_par = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            chk(!cpu_ready, "R8 ready low", cpu_ready, 0);
            chk(!init_done, "R9 done low while running", init_done, 0);
            chk(b0_cs && b0_we && b0_ewe && b1_cs && b1_we && b1_ewe, "R8 init write",
                {b0_cs, b0_we, b0_ewe, b1_cs, b1_we, b1_ewe}, 6'h3F);
            chk(b0_addr == AW'(i) && b1_addr == AW'(i), "R8 init order", b0_addr, AW'(i));
            chk(b0_wdata == exp_bank(IDATA, IECC, 0) && b1_wdata == exp_bank(IDATA, IECC, 1),
                "R8 init pattern", {b0_wdata, b1_wdata}, {exp_bank(IDATA, IECC, 0), exp_bank(IDATA, IECC, 1)});
            if (i > 0) chk(!cpu_rvalid, "R9 stalled request ignored", cpu_rvalid, 0);
            if (i == DEPTH - 1) cpu_req = 1'b0;
            @(negedge clk);
        end
        chk(cpu_ready, "R8 ready back after DEPTH cycles", cpu_ready, 1);
        chk(init_done, "R9 done set", init_done, 1);
        chk(!cpu_rvalid, "R9 no rvalid after stall", cpu_rvalid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m0[i] = '1; m1[i] = '1; end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(cpu_ready && !sbe_irq && !mbe_irq && !init_done && !addr_par_err && !dec_err
            && !b0_cs && !b1_cs, "R11 reset state",
            {cpu_ready, sbe_irq, mbe_irq, init_done, addr_par_err, dec_err, b0_cs, b1_cs}, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);

        run_init();
        for (int a = 0; a < DEPTH; a++) begin
            chk(m0[a] == exp_bank(IDATA, IECC, 0) && m1[a] == exp_bank(IDATA, IECC, 1),
                "R8 bank contents after init", {m0[a], m1[a]}, {exp_bank(IDATA, IECC, 0), exp_bank(IDATA, IECC, 1)});
        end
        do_read(5, 1'b0, 1'b1, IDATA, IECC);

        // R1/R2 sweep
        for (int a = 0; a < DEPTH; a++) do_write(a, pat_d(a), pat_e(a), 1'b0);
        for (int a = 0; a < DEPTH; a++) begin
            chk(m0[a] == exp_bank(pat_d(a), pat_e(a), 0), "R1 stored even bank", m0[a], exp_bank(pat_d(a), pat_e(a), 0));
            chk(m1[a] == exp_bank(pat_d(a), pat_e(a), 1), "R1 stored odd bank", m1[a], exp_bank(pat_d(a), pat_e(a), 1));
        end
        for (int a = DEPTH - 1; a >= 0; a--) do_read(a, 1'b0, 1'b1, pat_d(a), pat_e(a));

        // R3 bad parity: no write, no read
        for (int a = 0; a < DEPTH; a++) do_write(a, ~pat_d(a), ~pat_e(a), 1'b1);
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a, 1'b1, 1'b0, '0, '0);
            chk(addr_par_err, "R3 parity flag on read", addr_par_err, 1);
            do_read(a, 1'b0, 1'b0 == 1'b0, pat_d(a), pat_e(a));
            chk(!addr_par_err, "R3 parity flag one cycle", addr_par_err, 0);
        end

        // R10 out of range
        for (int a = DEPTH; a < (1 << AW); a++) begin
            do_write(a, 64'hDEAD, 8'h55, 1'b0);
            do_read(a, 1'b0, 1'b0, '0, '0);
        end

        // R5/R6/R7 error capture
        evt_sbe = 1'b1; evt_addr = 4'd3; @(negedge clk);
        evt_sbe = 1'b0;
        chk(sbe_irq && sbe_addr == 4'd3 && !mbe_irq, "R5 first capture", {sbe_irq, sbe_addr, mbe_irq}, {1'b1, 4'd3, 1'b0});
        evt_sbe = 1'b1; evt_addr = 4'd5; @(negedge clk);
        evt_sbe = 1'b0;
        chk(sbe_irq && sbe_addr == 4'd3, "R5 sticky address", sbe_addr, 4'd3);
        evt_mbe = 1'b1; evt_addr = 4'd9; @(negedge clk);
        evt_mbe = 1'b0;
        chk(mbe_irq && mbe_addr == 4'd9 && sbe_addr == 4'd3, "R6 independent capture", {mbe_addr, sbe_addr}, {4'd9, 4'd3});
        evt_mbe = 1'b1; evt_addr = 4'd1; @(negedge clk);
        evt_mbe = 1'b0;
        chk(mbe_addr == 4'd9, "R6 sticky address", mbe_addr, 4'd9);
        clr_sbe = 1'b1; @(negedge clk);
        clr_sbe = 1'b0;
        chk(!sbe_irq && mbe_irq, "R7 clear single", {sbe_irq, mbe_irq}, 2'b01);
        clr_mbe = 1'b1; evt_mbe = 1'b1; evt_addr = 4'd7; @(negedge clk);
        clr_mbe = 1'b0; evt_mbe = 1'b0;
        chk(mbe_irq && mbe_addr == 4'd7, "R7 clear with event recaptures", {mbe_irq, mbe_addr}, {1'b1, 4'd7});
        clr_mbe = 1'b1; @(negedge clk);
        clr_mbe = 1'b0;
        chk(!mbe_irq, "R7 clear multi", mbe_irq, 0);
        evt_sbe = 1'b1; evt_addr = 4'd11; @(negedge clk);
        evt_sbe = 1'b0;
        chk(sbe_irq && sbe_addr == 4'd11, "R5 capture after clear", sbe_addr, 4'd11);

        // second init overwrites user data
        run_init();
        do_read(2, 1'b0, 1'b1, IDATA, IECC);

        chk(!dec_seen, "R4 decoders agree", dec_seen, 0);
        finish_run();
    end
endmodule